// File: doc/BRIEF.md
# Sequenced Packet Verifier with CRC-16

This block checks one fixed-format packet that arrives as a stream of bytes, one byte per accepted cycle. A packet has four parts, in this order: a block number, the one's complement of that block number, a payload of `PAYLOAD_LEN` bytes (128 by default), and a 16-bit checksum.

While the payload passes through, the block runs a CRC-16 over it. Each payload byte is also forwarded on its own strobe in the same cycle it is accepted. After the last checksum byte, the block gives a single-cycle completion pulse with a verdict. The verdict is good only if all of these hold:

- the block number matches the index the surrounding logic expects;
- the complement byte is correct;
- the received checksum equals the computed one.

The controller is a state machine with six named states:

- `ST_SEQ0` waits for the block number. It is also the idle state. On a byte it latches the expected index, clears the CRC and the payload counter, and moves to `ST_SEQ1`.
- `ST_SEQ1` checks the complement and moves to `ST_DATA`.
- `ST_DATA` updates the CRC and forwards one byte per accepted cycle. It leaves for `ST_CRC_HI` on the last payload byte.
- `ST_CRC_HI` stores the upper checksum byte and moves to `ST_CRC_LO`.
- `ST_CRC_LO` forms the verdict and moves to `ST_DONE`.
- `ST_DONE` lasts exactly one cycle, raises the completion pulse, and returns to `ST_SEQ0`.

A cycle with `in_valid` low leaves every state unchanged.

Top module: `xmodem_pkt_checker`

## Requirements
- R1: While reset is held and in the cycle after it is released, `done`, `pass` and `pay_valid` are 0.
- R2: The first byte of a packet must equal `exp_idx` as sampled with that byte. Otherwise the verdict is fail.
- R3: The second byte must equal the bitwise inverse (8 bits) of the index latched with the first byte. Otherwise the verdict is fail.
- R4: Exactly `PAYLOAD_LEN` bytes follow the two header bytes. Each one appears on `pay_byte` with `pay_valid` high in the same cycle it is accepted. Header and checksum bytes are never forwarded.
- R5: The CRC starts at 0x0000 for every packet and has no final inversion. Per byte, the byte is XORed into bits 15:8 and the register is then shifted left eight times. On each shift the register is XORed with 0x1021 if bit 15 was 1 before that shift.
- R6: The received checksum is the upper byte first, then the lower byte. It is compared as {first, second} against the CRC.
- R7: `done` is high for exactly one cycle, in the cycle after the second checksum byte is accepted. `pass` is 1 only in that cycle and only if R2, R3 and the checksum compare all hold.
- R8: Cycles with `in_valid` low between bytes have no effect on the verdict or on the forwarded bytes.
- R9: A packet's verdict does not depend on any earlier packet, including one that failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exp_idx | input | 8 | Expected block number, sampled with the first byte |
| in_valid | input | 1 | A byte is offered on `in_byte` this cycle |
| in_byte | input | 8 | Incoming packet byte |
| pay_valid | output | 1 | `pay_byte` carries a payload byte this cycle |
| pay_byte | output | 8 | Forwarded payload byte |
| done | output | 1 | Single-cycle end-of-packet pulse |
| pass | output | 1 | Verdict, meaningful with `done` |

## Verification
The assertions assume three things about the input:

- a packet is always delivered in full;
- no byte is offered during the single `ST_DONE` cycle;
- reset starts the stream at a packet boundary.

The driver respects all three. It sends every packet complete and idles one cycle after each final checksum byte. It inserts idle cycles only between bytes of the same packet. Under those conditions, the count of payload strobes between two completion pulses must equal the payload length, and the pulse can only follow an accepted byte.

// File: rtl/pkt_chk_pkg.sv
package pkt_chk_pkg;
    localparam int BYTE_W = 8;
    localparam int CRC_W  = 16;

    typedef enum logic [2:0] {
        ST_SEQ0,
        ST_SEQ1,
        ST_DATA,
        ST_CRC_HI,
        ST_CRC_LO,
        ST_DONE
    } pkt_state_t;
endpackage

// File: rtl/crc16_byte_step.sv
module crc16_byte_step
    import pkt_chk_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] data,
    output logic [CRC_W-1:0]  crc_out
);
    localparam int PAD_W = CRC_W - BYTE_W;

    logic [CRC_W-1:0] acc;

    // Byte enters at the top; one conditional polynomial fold per bit.
    always_comb begin
        acc = crc_in ^ {data, {PAD_W{1'b0}}};
        for (int b = 0; b < BYTE_W; b++) begin
            if (acc[CRC_W-1])
                acc = (acc << 1) ^ POLY;
            else
                acc = acc << 1;
        end
        crc_out = acc;
    end
endmodule

// File: rtl/crc16_accum.sv
module crc16_accum
    import pkt_chk_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 16'h1021,
    parameter logic [CRC_W-1:0] SEED = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              update,
    input  logic [BYTE_W-1:0] data,
    output logic [CRC_W-1:0]  crc
);
    logic [CRC_W-1:0] crc_next;

    crc16_byte_step #(.POLY(POLY)) u_step (
        .crc_in  (crc),
        .data    (data),
        .crc_out (crc_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            crc <= SEED;
        else if (clear)
            crc <= SEED;
        else if (update)
            crc <= crc_next;
    end
endmodule

// File: rtl/payload_counter.sv
module payload_counter #(
    parameter int LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic last
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    assign last = (cnt == LAST_VAL);
endmodule

// File: rtl/xmodem_pkt_checker.sv
module xmodem_pkt_checker
    import pkt_chk_pkg::*;
#(
    parameter int               PAYLOAD_LEN = 128,
    parameter logic [CRC_W-1:0] CRC_POLY    = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] exp_idx,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              pay_valid,
    output logic [BYTE_W-1:0] pay_byte,
    output logic              done,
    output logic              pass
);
    pkt_state_t state_q, state_d;

    logic [BYTE_W-1:0] idx_q;
    logic [BYTE_W-1:0] crc_hi_q;
    logic              seq_ok_q;
    logic              verdict_q;
    logic [CRC_W-1:0]  crc_run;
    logic              pay_last;

    logic start_pkt, pay_beat;

    assign start_pkt = in_valid && (state_q == ST_SEQ0);
    assign pay_beat  = in_valid && (state_q == ST_DATA);

    crc16_accum #(.POLY(CRC_POLY), .SEED('0)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start_pkt),
        .update (pay_beat),
        .data   (in_byte),
        .crc    (crc_run)
    );

    payload_counter #(.LEN(PAYLOAD_LEN)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_pkt),
        .inc   (pay_beat),
        .last  (pay_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEQ0:   if (in_valid) state_d = ST_SEQ1;
            ST_SEQ1:   if (in_valid) state_d = ST_DATA;
            ST_DATA:   if (in_valid && pay_last) state_d = ST_CRC_HI;
            ST_CRC_HI: if (in_valid) state_d = ST_CRC_LO;
            ST_CRC_LO: if (in_valid) state_d = ST_DONE;
            ST_DONE:   state_d = ST_SEQ0;
            default:   state_d = ST_SEQ0;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_SEQ0;
        else
            state_q <= state_d;
    end

    // Header, checksum and verdict registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            seq_ok_q  <= 1'b0;
            crc_hi_q  <= '0;
            verdict_q <= 1'b0;
        end else if (in_valid) begin
            unique case (state_q)
                ST_SEQ0: begin
                    idx_q    <= exp_idx;
                    seq_ok_q <= (in_byte == exp_idx);
                end
                ST_SEQ1:   seq_ok_q <= seq_ok_q && (in_byte == ~idx_q);
                ST_CRC_HI: crc_hi_q <= in_byte;
                ST_CRC_LO: verdict_q <= seq_ok_q && ({crc_hi_q, in_byte} == crc_run);
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        pay_valid = pay_beat;
        pay_byte  = in_byte;
        done      = (state_q == ST_DONE);
        pass      = (state_q == ST_DONE) && verdict_q;
    end
endmodule

// File: rtl/xmodem_pkt_checker_chk.sv
module xmodem_pkt_checker_chk #(
    parameter int PAYLOAD_LEN = 128
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       pay_valid,
    input logic       done,
    input logic       pass
);
    localparam int BW = $clog2(PAYLOAD_LEN + 1) + 1;
    localparam logic [BW-1:0] FULL = BW'(PAYLOAD_LEN);

    logic [BW-1:0] beats;

    always_ff @(posedge clk) begin
        if (!rst_n)
            beats <= '0;
        else if (done)
            beats <= '0;
        else if (pay_valid)
            beats <= beats + 1'b1;
    end

    // R7
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    pass_only_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !pass);

    // R7
    done_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(in_valid));

    // R4
    payload_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> beats == FULL);

    // R4
    payload_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beats <= FULL);

    // R8
    strobe_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> in_valid);
endmodule

bind xmodem_pkt_checker xmodem_pkt_checker_chk #(.PAYLOAD_LEN(PAYLOAD_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .pay_valid (pay_valid),
    .done      (done),
    .pass      (pass)
);

// File: tb/xmodem_pkt_checker_bench.sv
module xmodem_pkt_checker_bench;
    localparam int LEN = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] exp_idx = 8'h00;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       pay_valid;
    logic [7:0] pay_byte;
    logic       done;
    logic       pass;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  mon_on   = 1'b0;
    bit  prev_done = 1'b0;
    bit  finished = 1'b0;

    logic [7:0] exp_pay_q[$];
    bit         exp_verdict_q[$];
    string      exp_tag_q[$];
    logic [7:0] pay[LEN];

    always #2 clk = ~clk;

    xmodem_pkt_checker u_xmodem_pkt_checker (
        .clk       (clk),
        .rst_n     (rst_n),
        .exp_idx   (exp_idx),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .pay_valid (pay_valid),
        .pay_byte  (pay_byte),
        .done      (done),
        .pass      (pass)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Checksum model written from R5
    function automatic logic [15:0] model_crc();
        logic [15:0] r = 16'h0000;
        for (int i = 0; i < LEN; i++) begin
            r = r ^ {pay[i], 8'h00};
            for (int k = 0; k < 8; k++) begin
                if (r[15]) r = {r[14:0], 1'b0} ^ 16'h1021;
                else       r = {r[14:0], 1'b0};
            end
        end
        return r;
    endfunction

    task automatic send_byte(input logic [7:0] b, input bit gap);
        if (gap) begin
            @(posedge clk); #1;
        end
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_byte  = 8'hxx;
    endtask

    // Driver: pushes expectations into the scoreboard, then drives the packet.
    task automatic send_packet(input logic [7:0] idx, input logic [7:0] s0, input logic [7:0] s1,
                               input logic [15:0] crc_flip, input bit swap, input bit gaps,
                               input string tag);
        logic [15:0] c, sent;
        logic [7:0]  first, second;
        c = model_crc();
        sent = c ^ crc_flip;
        first  = swap ? sent[7:0]  : sent[15:8];
        second = swap ? sent[15:8] : sent[7:0];
        for (int i = 0; i < LEN; i++) exp_pay_q.push_back(pay[i]);
        exp_verdict_q.push_back((s0 == idx) && (s1 == ~idx) && ({first, second} == c));
        exp_tag_q.push_back(tag);
        exp_idx = idx;
        send_byte(s0, 1'b0);
        exp_idx = ~idx;
        send_byte(s1, gaps);
        for (int i = 0; i < LEN; i++) send_byte(pay[i], gaps && (i % 3 == 0));
        send_byte(first, gaps);
        send_byte(second, gaps);
        @(posedge clk); #1;
    endtask

    // Monitor
    always @(negedge clk) begin
        if (mon_on) begin
            if (pay_valid) begin
                if (exp_pay_q.size() == 0)
                    check(1'b0, "R4 unexpected payload strobe", pay_byte, 0);
                else begin
                    logic [7:0] e;
                    e = exp_pay_q.pop_front();
                    check(pay_byte == e, "R4 forwarded byte", pay_byte, e);
                end
            end
            if (done) begin
                check(!prev_done, "R7 done longer than one cycle", 1, 0);
                check(exp_pay_q.size() == 0, "R4 payload count at done", exp_pay_q.size(), 0);
                if (exp_verdict_q.size() == 0)
                    check(1'b0, "R7 unexpected done", 1, 0);
                else begin
                    bit    v;
                    string t;
                    v = exp_verdict_q.pop_front();
                    t = exp_tag_q.pop_front();
                    check(pass == v, t, pass, v);
                end
            end else if (pass) begin
                check(1'b0, "R7 pass without done", 1, 0);
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs while in reset
        check(done == 1'b0 && pass == 1'b0 && pay_valid == 1'b0, "R1 in reset",
              {done, pass, pay_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: first cycle after release
        check(done == 1'b0 && pass == 1'b0 && pay_valid == 1'b0, "R1 after reset",
              {done, pass, pay_valid}, 0);
        @(posedge clk); #1;
        mon_on = 1'b1;

        // R2 R3 R5 R6: good packet, ramp payload
        for (int i = 0; i < LEN; i++) pay[i] = 8'(i);
        send_packet(8'h01, 8'h01, 8'hFE, 16'h0, 1'b0, 1'b0, "R5 good ramp");

        // R5: zero payload gives zero checksum with index 0
        for (int i = 0; i < LEN; i++) pay[i] = 8'h00;
        send_packet(8'h00, 8'h00, 8'hFF, 16'h0, 1'b0, 1'b0, "R5 zero payload");

        // R2: wrong block number
        for (int i = 0; i < LEN; i++) pay[i] = 8'(i * 37 + 3);
        send_packet(8'h05, 8'h06, 8'hFA, 16'h0, 1'b0, 1'b0, "R2 bad block number");

        // R3: wrong complement
        send_packet(8'h05, 8'h05, 8'hFB, 16'h0, 1'b0, 1'b0, "R3 bad complement");

        // R5: single bit error in checksum
        send_packet(8'h07, 8'h07, 8'hF8, 16'h0001, 1'b0, 1'b0, "R5 corrupt checksum");

        // R9: good packet right after a failing one
        send_packet(8'h08, 8'h08, 8'hF7, 16'h0, 1'b0, 1'b0, "R9 good after fail");

        // R6: checksum bytes swapped
        send_packet(8'h09, 8'h09, 8'hF6, 16'h0, 1'b1, 1'b0, "R6 swapped checksum");

        // R8: idle gaps, index 255, all-ones payload
        for (int i = 0; i < LEN; i++) pay[i] = 8'hFF;
        send_packet(8'hFF, 8'hFF, 8'h00, 16'h0, 1'b0, 1'b1, "R8 gapped good");

        // R8 R5: gaps with checksum error in the upper byte
        for (int i = 0; i < LEN; i++) pay[i] = 8'(255 - i);
        send_packet(8'h42, 8'h42, 8'hBD, 16'h8000, 1'b0, 1'b1, "R8 gapped corrupt");

        repeat (4) @(posedge clk);
        #1;
        check(exp_verdict_q.size() == 0, "R7 missing done", exp_verdict_q.size(), 0);
        check(exp_pay_q.size() == 0, "R4 missing payload", exp_pay_q.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule